// File: doc/BRIEF.md
# Serial Command and Status Port

This block is the host-facing end of a two-channel playback engine. A host talks to it over a byte-wide synchronous serial link with a chip select, a command strobe, a data strobe, a read strobe, a serial clock, a serial data input and a serial data output that has its own drive enable. A fast system clock oversamples every host pin through a synchronizer, so the block needs no second clock domain.

While chip select is low the port shifts serial data in, MSB first, on one serial clock edge. The serial clock level at the moment chip select falls picks which edge it uses. When the command strobe rises, the byte is handed to the core as a command. When the data strobe rises, it is handed over as a data byte. A strobe that closes a byte of the wrong length discards that byte and raises a one-cycle framing error. While chip select and the read strobe are both low, the port drives an 8-bit channel status byte out MSB first. The byte is frozen when the read strobe falls.

Top module: `scp_top`

## Requirements
- R1: While chip select is high, edges on the command, data and read strobes have no effect: no command, data or error pulse occurs and the output enable stays low.
- R2: If the serial clock is low when chip select falls, serial data is captured on rising serial clock edges.
- R3: If the serial clock is high when chip select falls, serial data is captured on falling serial clock edges.
- R4: The first captured bit lands in bit 7 of the delivered byte and the last in bit 0.
- R5: A command strobe rise that closes exactly 8 captured bits gives a one-cycle `cmd_valid` pulse with the byte on `rx_byte`.
- R6: A data strobe rise that closes exactly 8 captured bits gives a one-cycle `data_valid` pulse with the byte on `rx_byte`.
- R7: A strobe rise that closes a bit count other than 8 gives a one-cycle `frame_err` pulse and no valid pulse. The bit count restarts when chip select falls and after every strobe rise.
- R8: `do_oe` is high only while chip select and the read strobe are both low. At all other times DO is treated as high-impedance.
- R9: The status byte is {4'b0000, busy2, busy1, ncr2, ncr1}, bit 7 first. Bit 7 appears when the read starts, and the next bit appears after each selected serial clock edge.
- R10: The status byte is captured when the read strobe falls. Later changes on the status inputs do not alter the byte being shifted.
- R11: After reset all outputs are low. Each result appears 3 system clock cycles after the host pin change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the host pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Command strobe; a rising edge executes the byte |
| dw_n | input | 1 | Data strobe; a rising edge delivers the byte |
| rd_n | input | 1 | Status read strobe, active low |
| sck | input | 1 | Host serial clock |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial status data to the host |
| do_oe | output | 1 | Drive enable for sdo; low means high-impedance |
| st_busy1 | input | 1 | Channel 1 busy level from the core |
| st_busy2 | input | 1 | Channel 2 busy level from the core |
| st_ncr1 | input | 1 | Channel 1 ready-for-command level from the core |
| st_ncr2 | input | 1 | Channel 2 ready-for-command level from the core |
| rx_byte | output | 8 | Last delivered byte |
| cmd_valid | output | 1 | One-cycle pulse: rx_byte is a command |
| data_valid | output | 1 | One-cycle pulse: rx_byte is a data byte |
| frame_err | output | 1 | One-cycle pulse: wrong bit count, byte dropped |

## Verification
Every pin passes through two synchronizer flops and then an edge-detect register, so a strobe pulse, a captured status bit or a change of output enable appears on the third system clock edge after the pin moves. The bench changes pins on falling clock edges and samples results on the falling edge after the third rising edge, where each one-cycle pulse is stable. One directed test checks that `cmd_valid` is still low after two rising edges and high after three. Monitors count every pulse, so a spurious or duplicated strobe is caught even when it falls outside a sample point.

// File: rtl/scp_pkg.sv
package scp_pkg;
   localparam int unsigned STAT_FIELDS = 4;

   typedef struct packed {
      logic busy2;
      logic busy1;
      logic ncr2;
      logic ncr1;
   } scp_stat_t;

   function automatic logic [STAT_FIELDS-1:0] stat_bits(scp_stat_t s);
      return {s.busy2, s.busy1, s.ncr2, s.ncr1};
   endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int unsigned W = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("scp_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_rx.sv
module scp_rx #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              samp_i,
   input  logic              bit_i,
   input  logic              wr_rise_i,
   input  logic              dw_rise_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              cmd_valid_o,
   output logic              data_valid_o,
   output logic              err_o
);
   localparam int unsigned CNT_W   = $clog2(BYTE_W + 2);
   localparam int unsigned CNT_MAX = BYTE_W + 1;

   logic [BYTE_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              strobe, good;

   assign strobe = wr_rise_i | dw_rise_i;
   assign good   = (cnt == CNT_W'(BYTE_W)) && !(wr_rise_i && dw_rise_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh           <= '0;
         cnt          <= '0;
         byte_o       <= '0;
         cmd_valid_o  <= 1'b0;
         data_valid_o <= 1'b0;
         err_o        <= 1'b0;
      end else begin
         cmd_valid_o  <= 1'b0;
         data_valid_o <= 1'b0;
         err_o        <= 1'b0;
         if (clr_i) begin
            cnt <= '0;
         end else if (strobe) begin
            cnt <= '0;
            if (good) begin
               byte_o       <= sh;
               cmd_valid_o  <= wr_rise_i;
               data_valid_o <= dw_rise_i;
            end else begin
               err_o <= 1'b1;
            end
         end else if (samp_i) begin
            sh <= {sh[BYTE_W-2:0], bit_i};
            if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
         end
      end
   end

   a_r5_cmd_on_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise_i && !dw_rise_i && !clr_i && cnt == CNT_W'(BYTE_W)) |=> cmd_valid_o);

   a_r7_short_byte_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !clr_i && cnt != CNT_W'(BYTE_W)) |=> (err_o && !cmd_valid_o && !data_valid_o));
endmodule

// File: rtl/scp_tx.sv
module scp_tx #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              hold_i,
   input  logic              shift_i,
   input  logic [BYTE_W-1:0] status_i,
   output logic              sdo_o,
   output logic              oe_o
);
   logic [BYTE_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         oe_o <= 1'b0;
      end else if (load_i) begin
         sh   <= status_i;
         oe_o <= 1'b1;
      end else if (!hold_i) begin
         oe_o <= 1'b0;
      end else if (shift_i && oe_o) begin
         sh <= {sh[BYTE_W-2:0], 1'b0};
      end
   end

   assign sdo_o = oe_o & sh[BYTE_W-1];

   a_r8_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && !load_i) |=> !oe_o);

   a_r8_oe_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_o) |-> $past(load_i));
endmodule

// File: rtl/scp_top.sv
module scp_top #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              dw_n,
   input  logic              rd_n,
   input  logic              sck,
   input  logic              sdi,
   output logic              sdo,
   output logic              do_oe,
   input  logic              st_busy1,
   input  logic              st_busy2,
   input  logic              st_ncr1,
   input  logic              st_ncr2,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              cmd_valid,
   output logic              data_valid,
   output logic              frame_err
);
   import scp_pkg::*;

   localparam int unsigned PINS = 6;
   localparam logic [PINS-1:0] PIN_IDLE = 6'b111100;

   if (BYTE_W < STAT_FIELDS + 1) begin : g_bad_w
      $error("BYTE_W too small for the status layout");
   end

   logic [PINS-1:0] s_pins, p_pins;
   logic s_cs_n, s_wr_n, s_dw_n, s_rd_n, s_sck, s_di;
   logic p_cs_n, p_wr_n, p_dw_n, p_rd_n, p_sck;
   logic cs_act, cs_fall, wr_rise, dw_rise, rd_fall, samp_ev;
   logic fall_mode;
   scp_stat_t stat;
   logic [BYTE_W-1:0] stat_byte;

   scp_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({cs_n, wr_n, dw_n, rd_n, sck, sdi}),
      .q(s_pins)
   );

   assign {s_cs_n, s_wr_n, s_dw_n, s_rd_n, s_sck, s_di} = s_pins;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) p_pins <= PIN_IDLE;
      else        p_pins <= s_pins;

   assign {p_cs_n, p_wr_n, p_dw_n, p_rd_n, p_sck} = p_pins[PINS-1:1];

   assign cs_act  = !s_cs_n;
   assign cs_fall = cs_act & p_cs_n;
   assign wr_rise = cs_act & s_wr_n & !p_wr_n;
   assign dw_rise = cs_act & s_dw_n & !p_dw_n;
   assign rd_fall = cs_act & !s_rd_n & p_rd_n;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       fall_mode <= 1'b0;
      else if (cs_fall) fall_mode <= s_sck;

   assign samp_ev = cs_act & !cs_fall &
                    (fall_mode ? (!s_sck & p_sck) : (s_sck & !p_sck));

   assign stat      = '{busy2: st_busy2, busy1: st_busy1, ncr2: st_ncr2, ncr1: st_ncr1};
   assign stat_byte = BYTE_W'(stat_bits(stat));

   scp_rx #(.BYTE_W(BYTE_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .clr_i(cs_fall), .samp_i(samp_ev), .bit_i(s_di),
      .wr_rise_i(wr_rise), .dw_rise_i(dw_rise),
      .byte_o(rx_byte), .cmd_valid_o(cmd_valid),
      .data_valid_o(data_valid), .err_o(frame_err)
   );

   scp_tx #(.BYTE_W(BYTE_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .load_i(rd_fall), .hold_i(cs_act & !s_rd_n), .shift_i(samp_ev),
      .status_i(stat_byte), .sdo_o(sdo), .oe_o(do_oe)
   );

   a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid, data_valid, frame_err}));

   a_r1_cs_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (s_cs_n && p_cs_n) |=> !(cmd_valid || data_valid || frame_err || do_oe));
endmodule

// File: tb/scp_top_test.sv
`timescale 1ns/1ps
module scp_top_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, wr_n = 1'b1, dw_n = 1'b1, rd_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic st_busy1 = 1'b0, st_busy2 = 1'b0, st_ncr1 = 1'b0, st_ncr2 = 1'b0;
   logic sdo, do_oe, cmd_valid, data_valid, frame_err;
   logic [7:0] rx_byte;

   int tests = 0, fails = 0;
   int n_cmd = 0, n_dat = 0, n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   scp_top uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .dw_n(dw_n), .rd_n(rd_n),
      .sck(sck), .sdi(sdi), .sdo(sdo), .do_oe(do_oe),
      .st_busy1(st_busy1), .st_busy2(st_busy2), .st_ncr1(st_ncr1), .st_ncr2(st_ncr2),
      .rx_byte(rx_byte), .cmd_valid(cmd_valid), .data_valid(data_valid), .frame_err(frame_err)
   );

   always @(posedge clk) if (rst_n) begin
      if (cmd_valid)  n_cmd++;
      if (data_valid) n_dat++;
      if (frame_err)  n_err++;
   end

   // vector: {fall_edge_mode, use_data_strobe, bit_count[3:0], byte[7:0]}
   localparam int NV = 9;
   localparam logic [13:0] VEC [NV] = '{
      {1'b0, 1'b0, 4'd8, 8'hA5}, {1'b1, 1'b0, 4'd8, 8'h3C},
      {1'b0, 1'b1, 4'd8, 8'h81}, {1'b1, 1'b1, 4'd8, 8'h7E},
      {1'b0, 1'b0, 4'd7, 8'h55}, {1'b1, 1'b1, 4'd9, 8'hF0},
      {1'b0, 1'b0, 4'd8, 8'h01}, {1'b1, 1'b0, 4'd8, 8'h80},
      {1'b0, 1'b1, 4'd0, 8'h00}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic w4();
      repeat (4) @(negedge clk);
   endtask

   task automatic sample_due();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send(input bit fm, input bit use_dw, input int nbits, input logic [7:0] b);
      int c0, d0, e0;
      bit exp_ok, exp_cmd, exp_dat;
      c0 = n_cmd; d0 = n_dat; e0 = n_err;
      @(negedge clk); sck = fm; w4();
      cs_n = 1'b0; w4();
      if (use_dw) dw_n = 1'b0; else wr_n = 1'b0;
      w4();
      for (int i = 0; i < nbits; i++) begin
         sdi = (i < 8) ? b[7-i] : 1'b0;
         w4();
         sck = ~fm; w4();
         sck = fm;  w4();
      end
      if (use_dw) dw_n = 1'b1; else wr_n = 1'b1;
      sample_due();
      exp_ok  = (nbits == 8);
      exp_cmd = exp_ok && !use_dw;
      exp_dat = exp_ok && use_dw;
      chk(cmd_valid == exp_cmd, fm ? "R3/R5" : "R2/R5", "cmd_valid", cmd_valid, exp_cmd);
      chk(data_valid == exp_dat, "R6", "data_valid", data_valid, exp_dat);
      chk(frame_err == !exp_ok, "R7", "frame_err", frame_err, !exp_ok);
      if (exp_ok) chk(rx_byte == b, "R4", "rx_byte", rx_byte, b);
      w4();
      chk((n_cmd - c0) + (n_dat - d0) + (n_err - e0) == 1, "R5", "pulse count",
          (n_cmd - c0) + (n_dat - d0) + (n_err - e0), 1);
      cs_n = 1'b1; w4();
   endtask

   task automatic read_status(input bit fm, input logic [3:0] st, input logic [3:0] st_after);
      logic [7:0] exp;
      exp = {4'b0000, st};
      @(negedge clk);
      {st_busy2, st_busy1, st_ncr2, st_ncr1} = st;
      sck = fm; w4();
      cs_n = 1'b0; w4();
      rd_n = 1'b0;
      sample_due();
      chk(do_oe == 1'b1, "R8", "do_oe during read", do_oe, 1);
      chk(sdo == exp[7], "R9", "status bit 7", sdo, exp[7]);
      {st_busy2, st_busy1, st_ncr2, st_ncr1} = st_after;   // R10: must not leak in
      for (int i = 6; i >= 0; i--) begin
         sck = ~fm; w4();
         chk(sdo == exp[i], "R9/R10", $sformatf("status bit %0d", i), sdo, exp[i]);
         sck = fm; w4();
      end
      rd_n = 1'b1;
      sample_due();
      chk(do_oe == 1'b0, "R8", "do_oe after read", do_oe, 0);
      cs_n = 1'b1; w4();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      int c0, d0, e0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(do_oe == 0 && sdo == 0, "R11", "reset sdo/do_oe", {do_oe, sdo}, 0);
      chk({cmd_valid, data_valid, frame_err} == 0, "R11", "reset pulses",
          {cmd_valid, data_valid, frame_err}, 0);
      chk(rx_byte == 8'h00, "R11", "reset rx_byte", rx_byte, 0);
      rst_n = 1'b1;
      w4();

      foreach (VEC[k])
         send(VEC[k][13], VEC[k][12], int'(VEC[k][11:8]), VEC[k][7:0]);

      // R11: latency of a command strobe is exactly 3 rising edges
      @(negedge clk); sck = 1'b0; w4();
      cs_n = 1'b0; w4(); wr_n = 1'b0; w4();
      for (int i = 0; i < 8; i++) begin
         sdi = i[0]; w4(); sck = 1'b1; w4(); sck = 1'b0; w4();
      end
      wr_n = 1'b1;
      repeat (2) @(posedge clk); @(negedge clk);
      chk(cmd_valid == 1'b0, "R11", "cmd_valid after 2 edges", cmd_valid, 0);
      @(posedge clk); @(negedge clk);
      chk(cmd_valid == 1'b1, "R11", "cmd_valid after 3 edges", cmd_valid, 1);
      chk(rx_byte == 8'h55, "R4", "latency byte", rx_byte, 8'h55);
      w4(); cs_n = 1'b1; w4();

      // R9/R10: status reads in both edge modes
      read_status(1'b0, 4'b1011, 4'b0100);
      read_status(1'b1, 4'b0110, 4'b1001);

      // R1: strobes with chip select high are ignored
      c0 = n_cmd; d0 = n_dat; e0 = n_err;
      st_busy2 = 1'b1;
      wr_n = 1'b0; w4(); wr_n = 1'b1; w4();
      dw_n = 1'b0; w4(); dw_n = 1'b1; w4();
      rd_n = 1'b0; w4();
      chk(do_oe == 1'b0, "R1", "do_oe with cs high", do_oe, 0);
      rd_n = 1'b1; w4();
      chk((n_cmd - c0) + (n_dat - d0) + (n_err - e0) == 0, "R1", "pulses with cs high",
          (n_cmd - c0) + (n_dat - d0) + (n_err - e0), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule